// File: doc/BRIEF.md
# Local Bus to Peripheral Bus Bridge

This block sits on a processor's local data bus and splits each access between two targets. Accesses whose byte address falls inside a configurable window (`EXT_BASE` to `EXT_HIGH`, both ends included) are forwarded to a simple external peripheral bus. The address is passed through untranslated, together with 32-bit write data, four byte enables and a one-cycle address strobe qualified by a read or write strobe. The bridge then waits for the addressed peripheral to raise its ready handshake and hands the returned data and a completion pulse back to the processor.

Every other address is served by a small internal register file with fixed latency. A write takes effect on the edge that samples the strobe and completes in the next cycle. A read returns its data two cycles after the strobe. While an access is outstanding the bridge raises a wait indication and ignores new strobes. The two error-correction status outputs of the processor interface are tied low.

Top module: `lbus_bridge`

## Requirements
- R1: After reset, `cpu_ready_o`, `cpu_wait_o`, `cpu_rdata_o` and all external strobes are low, and every internal register reads as zero.
- R2: An access is forwarded to the external bus exactly when its byte address A satisfies `EXT_BASE <= A <= EXT_HIGH`. Any other address selects internal register `A[IDX_W+1:2]`, and no external strobe is produced for it.
- R3: A forwarded access drives `per_as_o` for exactly one cycle, in the cycle after the processor strobe. In that cycle exactly one of `per_rs_o`/`per_ws_o` is high (write when `cpu_ws_i` was high). `per_addr_o` equals the processor address. `per_addr_o`, `per_be_o` and `per_wdata_o` stay unchanged until the cycle in which `per_ready_i` is high.
- R4: When the peripheral raises `per_ready_i` W cycles after the `per_as_o` cycle, `cpu_ready_o` pulses in cycle T+3+W, where T is the processor strobe cycle. A read returns the `per_rdata_i` value present in the ready cycle. `cpu_wait_o` is high from T+1 through T+2+W.
- R5: An internal write (`cpu_ws_i` high) updates, at the edge that samples the strobe, each byte lane b (bits 8b+7:8b) whose `cpu_be_i[b]` is 1 and keeps the other lanes. `cpu_ready_o` pulses in T+1 with no wait cycle.
- R6: An internal read (`cpu_rs_i` high, `cpu_ws_i` low) raises `cpu_wait_o` in T+1 and pulses `cpu_ready_o` in T+2, with the register contents on `cpu_rdata_o`.
- R7: A processor strobe arriving while `cpu_wait_o` is high is ignored. It changes no register, produces no external strobe and does not disturb the access in progress.
- R8: `cpu_rdata_o` is zero in every cycle without `cpu_ready_o`, and write completions return zero.
- R9: `cpu_corr_err_o` and `cpu_uncorr_err_o` are always zero.
- R10: `per_ready_i` raised while no external access is open produces no `cpu_ready_o`.
- R11: A new strobe may be issued in the completion cycle, so back-to-back zero-wait external accesses complete one every three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_as_i | input | 1 | Processor address strobe |
| cpu_rs_i | input | 1 | Processor read strobe |
| cpu_ws_i | input | 1 | Processor write strobe |
| cpu_addr_i | input | 32 | Processor byte address |
| cpu_be_i | input | 4 | Processor byte enables |
| cpu_wdata_i | input | 32 | Processor write data |
| cpu_rdata_o | output | 32 | Read data to processor, valid with ready |
| cpu_ready_o | output | 1 | Access completion pulse |
| cpu_wait_o | output | 1 | Access outstanding |
| cpu_corr_err_o | output | 1 | Correctable error, tied low |
| cpu_uncorr_err_o | output | 1 | Uncorrectable error, tied low |
| per_as_o | output | 1 | External address strobe |
| per_rs_o | output | 1 | External read strobe |
| per_ws_o | output | 1 | External write strobe |
| per_addr_o | output | 32 | External byte address |
| per_be_o | output | 4 | External byte enables |
| per_wdata_o | output | 32 | External write data |
| per_rdata_i | input | 32 | External read data |
| per_ready_i | input | 1 | External ready handshake |

## Verification
The bridge is driven with internal full-word and partial byte-enable writes followed by readbacks, which separates lane masking from whole-word replacement. External reads and writes with 0, 1, 2, 3 and 5 wait states show whether completion tracks the peripheral's ready or a fixed count. Addresses one word below the window, at both window edges and one byte above it show whether decode boundaries are inclusive, and aliased internal addresses show the index field. Strobes sent into a busy bridge, a stray ready pulse at idle, and two external reads issued back to back separate correct gating from accidental acceptance and show the three-cycle throughput.

// File: rtl/lbus_bridge_pkg.sv
package lbus_bridge_pkg;
    localparam int unsigned AW = 32;
    localparam int unsigned DW = 32;
    localparam int unsigned BW = DW / 8;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_INT_RD = 2'd1,
        PH_EXT    = 2'd2
    } phase_e;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [BW-1:0] be;
        logic [DW-1:0] wdata;
    } xfer_t;
endpackage

// File: rtl/lbus_bridge_decode.sv
module lbus_bridge_decode
    import lbus_bridge_pkg::*;
#(
    parameter logic [AW-1:0] BASE  = 32'h8000_0000,
    parameter logic [AW-1:0] HIGH  = 32'h8000_FFFF,
    parameter int unsigned   IDX_W = 3
) (
    input  logic [AW-1:0]    addr_i,
    output logic             ext_hit_o,
    output logic [IDX_W-1:0] idx_o
);
    // Inclusive window compare on the full byte address.
    assign ext_hit_o = (addr_i >= BASE) && (addr_i <= HIGH);
    // Word index into the internal register file.
    assign idx_o     = addr_i[IDX_W+1:2];
endmodule

// File: rtl/lbus_bridge_regfile.sv
module lbus_bridge_regfile
    import lbus_bridge_pkg::*;
#(
    parameter int unsigned NREGS = 8,
    parameter int unsigned IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [BW-1:0]    be_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [IDX_W-1:0] ridx_i,
    output logic [DW-1:0]    rdata_o
);
    logic [DW-1:0] mem_q [NREGS];
    logic [DW-1:0] mem_d [NREGS];
    logic [DW-1:0] lane_mask;

    // One mask byte per enable bit.
    for (genvar g = 0; g < BW; g++) begin : g_lane
        assign lane_mask[8*g +: 8] = {8{be_i[g]}};
    end

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[widx_i] = (mem_q[widx_i] & ~lane_mask) | (wdata_i & lane_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/lbus_bridge_extport.sv
module lbus_bridge_extport
    import lbus_bridge_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  xfer_t         xfer_i,
    input  logic          per_ready_i,
    input  logic [DW-1:0] per_rdata_i,
    output logic          per_as_o,
    output logic          per_rs_o,
    output logic          per_ws_o,
    output logic [AW-1:0] per_addr_o,
    output logic [BW-1:0] per_be_o,
    output logic [DW-1:0] per_wdata_o,
    output logic          done_o,
    output logic [DW-1:0] rdata_o
);
    typedef struct packed {
        logic          busy;
        logic          as;
        logic          rs;
        logic          ws;
        xfer_t         hold;
        logic          done;
        logic [DW-1:0] rdata;
    } ext_state_t;

    ext_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.as   = 1'b0;
        st_d.rs   = 1'b0;
        st_d.ws   = 1'b0;
        st_d.done = 1'b0;
        if (start_i && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.as   = 1'b1;
            st_d.rs   = !xfer_i.wr;
            st_d.ws   = xfer_i.wr;
            st_d.hold = xfer_i;
        end else if (st_q.busy && per_ready_i) begin
            // Peripheral handshake closes the access; capture data now.
            st_d.busy  = 1'b0;
            st_d.done  = 1'b1;
            st_d.rdata = st_q.hold.wr ? '0 : per_rdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign per_as_o    = st_q.as;
    assign per_rs_o    = st_q.rs;
    assign per_ws_o    = st_q.ws;
    assign per_addr_o  = st_q.hold.addr;
    assign per_be_o    = st_q.hold.be;
    assign per_wdata_o = st_q.hold.wdata;
    assign done_o      = st_q.done;
    assign rdata_o     = st_q.rdata;
endmodule

// File: rtl/lbus_bridge.sv
module lbus_bridge
    import lbus_bridge_pkg::*;
#(
    parameter logic [AW-1:0] EXT_BASE = 32'h8000_0000,
    parameter logic [AW-1:0] EXT_HIGH = 32'h8000_FFFF,
    parameter int unsigned   NREGS    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_as_i,
    input  logic          cpu_rs_i,
    input  logic          cpu_ws_i,
    input  logic [31:0]   cpu_addr_i,
    input  logic [3:0]    cpu_be_i,
    input  logic [31:0]   cpu_wdata_i,
    output logic [31:0]   cpu_rdata_o,
    output logic          cpu_ready_o,
    output logic          cpu_wait_o,
    output logic          cpu_corr_err_o,
    output logic          cpu_uncorr_err_o,
    output logic          per_as_o,
    output logic          per_rs_o,
    output logic          per_ws_o,
    output logic [31:0]   per_addr_o,
    output logic [3:0]    per_be_o,
    output logic [31:0]   per_wdata_o,
    input  logic [31:0]   per_rdata_i,
    input  logic          per_ready_i
);
    localparam int unsigned IDX_W = $clog2(NREGS);

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] ridx;
        logic             ready;
        logic [DW-1:0]    rdata;
    } top_state_t;

    top_state_t st_q, st_d;

    logic             ext_hit;
    logic [IDX_W-1:0] idx;
    logic             accept;
    logic             ext_start;
    logic             int_wr;
    logic [DW-1:0]    rf_rdata;
    logic             ext_done;
    logic [DW-1:0]    ext_rdata;
    xfer_t            xfer;

    lbus_bridge_decode #(
        .BASE (EXT_BASE),
        .HIGH (EXT_HIGH),
        .IDX_W(IDX_W)
    ) u_decode (
        .addr_i   (cpu_addr_i),
        .ext_hit_o(ext_hit),
        .idx_o    (idx)
    );

    // New accesses are taken only when nothing is outstanding.
    assign accept    = cpu_as_i && (cpu_rs_i || cpu_ws_i) && (st_q.phase == PH_IDLE);
    assign ext_start = accept && ext_hit;
    assign int_wr    = accept && !ext_hit && cpu_ws_i;

    assign xfer.wr    = cpu_ws_i;
    assign xfer.addr  = cpu_addr_i;
    assign xfer.be    = cpu_be_i;
    assign xfer.wdata = cpu_wdata_i;

    lbus_bridge_regfile #(
        .NREGS(NREGS),
        .IDX_W(IDX_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (int_wr),
        .widx_i (idx),
        .be_i   (cpu_be_i),
        .wdata_i(cpu_wdata_i),
        .ridx_i (st_q.ridx),
        .rdata_o(rf_rdata)
    );

    lbus_bridge_extport u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (ext_start),
        .xfer_i     (xfer),
        .per_ready_i(per_ready_i),
        .per_rdata_i(per_rdata_i),
        .per_as_o   (per_as_o),
        .per_rs_o   (per_rs_o),
        .per_ws_o   (per_ws_o),
        .per_addr_o (per_addr_o),
        .per_be_o   (per_be_o),
        .per_wdata_o(per_wdata_o),
        .done_o     (ext_done),
        .rdata_o    (ext_rdata)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ready = 1'b0;
        st_d.rdata = '0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (ext_start) begin
                    st_d.phase = PH_EXT;
                end else if (int_wr) begin
                    st_d.ready = 1'b1;
                end else if (accept) begin
                    st_d.phase = PH_INT_RD;
                    st_d.ridx  = idx;
                end
            end
            PH_INT_RD: begin
                st_d.ready = 1'b1;
                st_d.rdata = rf_rdata;
                st_d.phase = PH_IDLE;
            end
            PH_EXT: begin
                if (ext_done) begin
                    st_d.ready = 1'b1;
                    st_d.rdata = ext_rdata;
                    st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_ready_o      = st_q.ready;
    assign cpu_rdata_o      = st_q.rdata;
    assign cpu_wait_o       = (st_q.phase != PH_IDLE);
    assign cpu_corr_err_o   = 1'b0;
    assign cpu_uncorr_err_o = 1'b0;
endmodule

// File: rtl/lbus_bridge_chk.sv
module lbus_bridge_chk #(
    parameter logic [31:0] BASE = 32'h8000_0000,
    parameter logic [31:0] HIGH = 32'h8000_FFFF
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_as,
    input logic        cpu_rs,
    input logic        cpu_ws,
    input logic [31:0] cpu_addr,
    input logic [31:0] cpu_rdata,
    input logic        cpu_ready,
    input logic        cpu_wait,
    input logic        ce,
    input logic        ue,
    input logic        per_as,
    input logic        per_rs,
    input logic        per_ws,
    input logic [31:0] per_addr,
    input logic [3:0]  per_be,
    input logic [31:0] per_wdata,
    input logic        per_ready
);
    logic in_win;
    logic open_q;
    logic active;

    assign in_win = (cpu_addr >= BASE) && (cpu_addr <= HIGH);
    assign active = per_as || open_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         open_q <= 1'b0;
        else if (per_ready) open_q <= 1'b0;
        else if (per_as)    open_q <= 1'b1;
    end

    p_err_tied_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ce && !ue);

    p_fwd_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        per_as |-> ($past(cpu_as) && $past(in_win) && per_addr == $past(cpu_addr)));

    p_int_no_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_as && !cpu_wait && !in_win) |=> !per_as);

    p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        per_as |=> !per_as);

    p_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        per_as |-> (per_rs != per_ws));

    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !per_as |-> (!per_rs && !per_ws));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !per_ready) |=> ($stable(per_addr) && $stable(per_be) && $stable(per_wdata)));

    p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wait && cpu_ready));

    p_int_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_as && cpu_ws && !cpu_wait && !in_win) |=> (cpu_ready && !cpu_wait));

    p_int_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_as && cpu_rs && !cpu_ws && !cpu_wait && !in_win) |=> (cpu_wait && !cpu_ready) ##1 cpu_ready);

    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wait |=> !per_as);

    p_rdata_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |-> (cpu_rdata == 32'h0));

    p_ready_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> ($past(cpu_wait) || $past(cpu_as && cpu_ws && !in_win)));
endmodule

bind lbus_bridge lbus_bridge_chk #(
    .BASE(EXT_BASE),
    .HIGH(EXT_HIGH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_as   (cpu_as_i),
    .cpu_rs   (cpu_rs_i),
    .cpu_ws   (cpu_ws_i),
    .cpu_addr (cpu_addr_i),
    .cpu_rdata(cpu_rdata_o),
    .cpu_ready(cpu_ready_o),
    .cpu_wait (cpu_wait_o),
    .ce       (cpu_corr_err_o),
    .ue       (cpu_uncorr_err_o),
    .per_as   (per_as_o),
    .per_rs   (per_rs_o),
    .per_ws   (per_ws_o),
    .per_addr (per_addr_o),
    .per_be   (per_be_o),
    .per_wdata(per_wdata_o),
    .per_ready(per_ready_i)
);

// File: tb/lbus_bridge_test.sv
module lbus_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_as = 1'b0, cpu_rs = 1'b0, cpu_ws = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready, cpu_wait, ce, ue;
    logic        per_as, per_rs, per_ws;
    logic [31:0] per_addr, per_wdata;
    logic [3:0]  per_be;
    logic [31:0] per_rdata = '0;
    logic        pm_ready = 1'b0, stray_ready = 1'b0;
    logic        per_ready;

    int nchk = 0, nerr = 0;
    int cyc = 0;
    int ws_cfg = 0;
    int seen = 0, proto_err = 0;
    logic [31:0] s_addr, s_wd;
    logic [3:0]  s_be;
    logic        s_wr;

    assign per_ready = pm_ready | stray_ready;

    always #5 clk = ~clk;

    lbus_bridge uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_as_i(cpu_as), .cpu_rs_i(cpu_rs), .cpu_ws_i(cpu_ws),
        .cpu_addr_i(cpu_addr), .cpu_be_i(cpu_be), .cpu_wdata_i(cpu_wdata),
        .cpu_rdata_o(cpu_rdata), .cpu_ready_o(cpu_ready), .cpu_wait_o(cpu_wait),
        .cpu_corr_err_o(ce), .cpu_uncorr_err_o(ue),
        .per_as_o(per_as), .per_rs_o(per_rs), .per_ws_o(per_ws),
        .per_addr_o(per_addr), .per_be_o(per_be), .per_wdata_o(per_wdata),
        .per_rdata_i(per_rdata), .per_ready_i(per_ready)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [2:0]  ws;
        logic        ext;
        logic [3:0]  lat;
        logic [31:0] rd;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_0004, 1'b1, 4'hF, 32'h1122_3344, 3'd0, 1'b0, 4'd1, 32'h0},
        '{32'h0000_0004, 1'b0, 4'hF, 32'h0,         3'd0, 1'b0, 4'd2, 32'h1122_3344},
        '{32'h0000_0004, 1'b1, 4'h5, 32'hAABB_CCDD, 3'd0, 1'b0, 4'd1, 32'h0},
        '{32'h0000_0004, 1'b0, 4'hF, 32'h0,         3'd0, 1'b0, 4'd2, 32'h11BB_33DD},
        '{32'h8000_0000, 1'b0, 4'hF, 32'h0,         3'd0, 1'b1, 4'd3, 32'h7FFF_FFFF},
        '{32'h8000_0010, 1'b1, 4'h3, 32'hCAFE_F00D, 3'd2, 1'b1, 4'd5, 32'h0},
        '{32'h8000_FFFC, 1'b0, 4'hF, 32'h0,         3'd5, 1'b1, 4'd8, 32'h7FFF_0003},
        '{32'h7FFF_FFFC, 1'b1, 4'hF, 32'h0BAD_CAFE, 3'd0, 1'b0, 4'd1, 32'h0},
        '{32'h8001_0000, 1'b0, 4'hF, 32'h0,         3'd0, 1'b0, 4'd2, 32'h0},
        '{32'h0000_001C, 1'b0, 4'hF, 32'h0,         3'd0, 1'b0, 4'd2, 32'h0BAD_CAFE},
        '{32'h8000_8000, 1'b1, 4'h8, 32'h1234_5678, 3'd1, 1'b1, 4'd4, 32'h0},
        '{32'h8000_FFFF, 1'b0, 4'hF, 32'h0,         3'd3, 1'b1, 4'd6, 32'h7FFF_0000}
    };

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] a, input logic w, input logic [3:0] be,
                         input logic [31:0] wd);
        cpu_as = 1'b1; cpu_rs = !w; cpu_ws = w;
        cpu_addr = a; cpu_be = be; cpu_wdata = wd;
    endtask

    task automatic idle_bus();
        cpu_as = 1'b0; cpu_rs = 1'b0; cpu_ws = 1'b0;
        cpu_addr = '0; cpu_be = '0; cpu_wdata = '0;
    endtask

    // Called at a falling edge; drives the strobe in the current cycle.
    task automatic run_access(input vec_t v, input string tag);
        int s0 = seen;
        int lat = 0;
        int waitc = 0;
        logic zero_ok = 1'b1;
        logic [31:0] rd = '0;
        ws_cfg = int'(v.ws);
        drive(v.addr, v.wr, v.be, v.wdata);
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (k == 1) idle_bus();
            if (cpu_ready) begin
                lat = k; rd = cpu_rdata;
                break;
            end
            if (cpu_wait) waitc++;
            if (cpu_rdata != 32'h0) zero_ok = 1'b0;
        end
        chk(lat == int'(v.lat), tag, "completion cycle", lat, v.lat);
        chk(rd == v.rd, tag, "returned data", rd, v.rd);
        chk(waitc == int'(v.lat) - 1, tag, "wait cycles", waitc, v.lat - 1);
        chk(zero_ok, "R8", "rdata zero before ready", {31'b0, zero_ok}, 32'h1);
        chk((seen - s0) == int'(v.ext), "R2", "forwarding decision", seen - s0, v.ext);
        if (v.ext && (seen - s0) == 1) begin
            chk(s_addr == v.addr, "R3", "forwarded address", s_addr, v.addr);
            chk(s_wr == v.wr, "R3", "forwarded direction", s_wr, v.wr);
            chk(s_be == v.be, "R3", "forwarded byte enables", s_be, v.be);
            if (v.wr) chk(s_wd == v.wdata, "R3", "forwarded write data", s_wd, v.wdata);
        end
    endtask

    // Peripheral model: answers each strobe after ws_cfg wait states.
    initial begin
        forever begin
            @(negedge clk);
            if (per_as) begin
                seen++;
                s_addr = per_addr; s_wr = per_ws; s_be = per_be; s_wd = per_wdata;
                if (per_rs == per_ws) proto_err++;
                for (int i = 0; i < ws_cfg; i++) begin
                    @(negedge clk);
                    if (per_as || per_addr != s_addr || per_be != s_be || per_wdata != s_wd)
                        proto_err++;
                end
                per_rdata = ~per_addr;
                pm_ready = 1'b1;
                @(negedge clk);
                pm_ready = 1'b0;
                per_rdata = '0;
                if (per_as) proto_err++;
            end
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        vec_t v;
        int s0, lat, t0;
        logic [31:0] rd;
        logic quiet;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!cpu_ready && !cpu_wait, "R1", "ready/wait after reset", {cpu_ready, cpu_wait}, 0);
        chk(cpu_rdata == 0, "R1", "rdata after reset", cpu_rdata, 0);
        chk(!per_as && !per_rs && !per_ws, "R1", "external strobes after reset",
            {per_as, per_rs, per_ws}, 0);
        chk(!ce && !ue, "R9", "error outputs", {ce, ue}, 0);
        v = '{32'h0000_000C, 1'b0, 4'hF, 32'h0, 3'd0, 1'b0, 4'd2, 32'h0};
        run_access(v, "R1");

        // Table walk: R5 internal writes, R6 internal reads, R4 external accesses
        for (int i = 0; i < NV; i++) begin
            run_access(VEC[i], VEC[i].ext ? "R4" : (VEC[i].wr ? "R5" : "R6"));
        end

        // R7: strobes while busy are ignored
        ws_cfg = 3; s0 = seen; lat = 0; rd = '0;
        drive(32'h8000_0100, 1'b0, 4'hF, 32'h0);
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (k == 1) drive(32'h0000_0008, 1'b1, 4'hF, 32'hFFFF_FFFF);
            else if (k == 2) drive(32'h8000_0200, 1'b1, 4'hF, 32'h5555_AAAA);
            else if (k == 3) idle_bus();
            if (cpu_ready) begin
                lat = k; rd = cpu_rdata;
                break;
            end
        end
        chk(lat == 6, "R7", "busy access completion cycle", lat, 6);
        chk(rd == 32'h7FFF_FEFF, "R7", "busy access data", rd, 32'h7FFF_FEFF);
        chk(seen - s0 == 1, "R7", "external strobes while busy", seen - s0, 1);
        chk(s_addr == 32'h8000_0100, "R7", "forwarded address", s_addr, 32'h8000_0100);
        v = '{32'h0000_0008, 1'b0, 4'hF, 32'h0, 3'd0, 1'b0, 4'd2, 32'h0};
        run_access(v, "R7");

        // R10: stray ready while idle
        quiet = 1'b1;
        stray_ready = 1'b1;
        @(negedge clk);
        stray_ready = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (cpu_ready || cpu_wait) quiet = 1'b0;
        end
        chk(quiet, "R10", "no completion from stray ready", {31'b0, quiet}, 1);

        // R11: back-to-back zero-wait external reads
        t0 = cyc;
        v = '{32'h8000_0040, 1'b0, 4'hF, 32'h0, 3'd0, 1'b1, 4'd3, 32'h7FFF_FFBF};
        run_access(v, "R11");
        v = '{32'h8000_0044, 1'b0, 4'hF, 32'h0, 3'd0, 1'b1, 4'd3, 32'h7FFF_FFBB};
        run_access(v, "R11");
        chk(cyc - t0 == 6, "R11", "cycles for two accesses", cyc - t0, 6);

        repeat (3) @(negedge clk);
        chk(proto_err == 0, "R3", "strobe pulse and hold protocol", proto_err, 0);
        chk(!ce && !ue, "R9", "error outputs at end", {ce, ue}, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule